// File: doc/BRIEF.md
# Table-Driven Constant Multiplier

This block multiplies an 8-bit unsigned operand by an 8-bit constant and returns the full 16-bit product. The constant is never stored as a number. It lives in four small rewritable lookup tables. Each constant nibble owns two 16-entry tables: one is indexed by the operand's low nibble and one by its high nibble. Each entry holds the index times that constant nibble. The two table outputs for one constant nibble are combined with a 4-bit offset to form a 12-bit partial product. The partial product for the low constant nibble is added unshifted. The one for the high constant nibble is shifted left by four.

The constant is changed at run time by rewriting table contents only; the datapath does not change. There are two ways to do this. Software-style writes put one entry per clock into a chosen table. A fill sequencer writes all four tables from a single 8-bit constant. It runs in three states: `FILL_IDLE`, `FILL_RUN` and `FILL_DONE`. A `fill_start` seen in `FILL_IDLE` with `load_en` low moves it to `FILL_RUN`. `FILL_RUN` writes addresses 0 to 15 into all tables, one address per cycle. After address 15 it moves to `FILL_DONE`. `FILL_DONE` returns to `FILL_IDLE` after one cycle. While either method is writing, results are marked invalid. After reset the tables hold the products for constant 171 (0xAB).

Top module: `lutmul_const_mult`

## Requirements
- R1: After reset, out_valid, fill_busy and fill_done are 0, out_product is 0, and the tables hold the entries for constant 0xAB, so the first products equal operand × 171.
- R2: With the default registered output, an operand taken with in_valid high is answered one clock later. out_valid is 1 and out_product equals operand × constant, for every one of the 256 operands.
- R3: out_product keeps its last value in every cycle whose input was not accepted.
- R4: While load_en is high and no fill runs, each clock writes load_data into entry load_addr of the table picked by load_sel. The select codes are: 0 = low constant nibble indexed by operand bits 3:0; 1 = low constant nibble indexed by operand bits 7:4; 2 = high constant nibble indexed by operand bits 3:0; 3 = high constant nibble indexed by operand bits 7:4. The product is T0[lo] + 16·T1[hi] + 16·(T2[lo] + 16·T3[hi]).
- R5: An input presented in a cycle where load_en or fill_busy is high is not accepted. It produces no out_valid one clock later.
- R6: A fill_start sampled in FILL_IDLE with load_en low loads all four tables for fill_const. fill_busy is high for the 16 cycles after that edge. fill_done is a single-cycle pulse on the 17th edge, and the new constant is used from then on.
- R7: While a fill runs, load_en writes and further fill_start pulses are ignored.
- R8: A fill_start sampled while load_en is high is ignored, and fill_busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand qualifier |
| in_data | input | 8 | Unsigned operand |
| out_valid | output | 1 | Product qualifier |
| out_product | output | 16 | operand × constant |
| load_en | input | 1 | Write one table entry this cycle |
| load_sel | input | 2 | Table select (codes in R4) |
| load_addr | input | 4 | Entry index |
| load_data | input | 8 | Entry value |
| fill_start | input | 1 | Start filling all tables |
| fill_const | input | 8 | Constant used by the fill |
| fill_busy | output | 1 | Fill sequencer writing |
| fill_done | output | 1 | One-cycle end-of-fill pulse |

## Verification
Every accepted operand is answered on the clock edge right after the one that sampled it. The driver changes inputs on the falling edge and queues the product it expects. The monitor samples 2 ns after the next rising edge, where that single queued item must meet out_valid. The fill timing is counted in falling edges from the edge that set fill_start. fill_busy must be seen at the first through sixteenth falling edges after the sampling edge. fill_done must be seen only at the seventeenth. Inputs presented during loads and fills are held back from the queue, so any out_valid one edge later shows up as an unexpected result.

// File: rtl/lutmul_pkg.sv
package lutmul_pkg;

    typedef enum logic [1:0] {
        FILL_IDLE = 2'd0,
        FILL_RUN  = 2'd1,
        FILL_DONE = 2'd2
    } fill_state_t;

    // Number of tables per constant nibble and number of constant nibbles
    localparam int TBL_PER_PART = 2;
    localparam int NUM_PARTS    = 2;
    localparam int NUM_TABLES   = TBL_PER_PART * NUM_PARTS;

endpackage

// File: rtl/lutmul_table.sv
module lutmul_table #(
    parameter int IDX_W = 4,
    parameter int ENT_W = 8,
    parameter logic [IDX_W-1:0] INIT_NIB = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [ENT_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [ENT_W-1:0] rd_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [ENT_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= ENT_W'(i) * ENT_W'(INIT_NIB);
            end
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem[$past(wr_addr)] == $past(wr_data)); // R4

endmodule

// File: rtl/lutmul_partial.sv
module lutmul_partial #(
    parameter int NIB_W = 4,
    parameter int ENT_W = 8,
    parameter int PP_W  = 12,
    parameter logic [NIB_W-1:0] INIT_NIB = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         wr_en,
    input  logic [NIB_W-1:0]   wr_addr,
    input  logic [ENT_W-1:0]   wr_data,
    input  logic [2*NIB_W-1:0] operand,
    output logic [PP_W-1:0]    pp
);
    logic [ENT_W-1:0] rd [2];

    for (genvar t = 0; t < 2; t++) begin : g_tbl
        lutmul_table #(
            .IDX_W   (NIB_W),
            .ENT_W   (ENT_W),
            .INIT_NIB(INIT_NIB)
        ) u_tbl (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_en[t]),
            .wr_addr(wr_addr),
            .wr_data(wr_data),
            .rd_addr(operand[t*NIB_W +: NIB_W]),
            .rd_data(rd[t])
        );
    end

    // Table indexed by the upper operand nibble carries weight 2^NIB_W
    assign pp = PP_W'(rd[0]) + (PP_W'(rd[1]) << NIB_W);

endmodule

// File: rtl/lutmul_filler.sv
module lutmul_filler
    import lutmul_pkg::*;
#(
    parameter int NIB_W = 4,
    parameter int ENT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               hold,
    input  logic [2*NIB_W-1:0] const_in,
    output logic               busy,
    output logic               done,
    output logic               wr_en,
    output logic [NIB_W-1:0]   wr_addr,
    output logic [ENT_W-1:0]   lo_data,
    output logic [ENT_W-1:0]   hi_data
);
    localparam logic [NIB_W-1:0] LAST = {NIB_W{1'b1}};

    fill_state_t state_q, state_d;
    logic [NIB_W-1:0]   addr_q;
    logic [2*NIB_W-1:0] const_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FILL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FILL_IDLE: if (start && !hold) state_d = FILL_RUN;
            FILL_RUN:  if (addr_q == LAST) state_d = FILL_DONE;
            FILL_DONE: state_d = FILL_IDLE;
            default:   state_d = FILL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            const_q <= '0;
        end else if (state_q == FILL_IDLE && start && !hold) begin
            addr_q  <= '0;
            const_q <= const_in;
        end else if (state_q == FILL_RUN) begin
            addr_q  <= addr_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        busy    = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            FILL_IDLE: ;
            FILL_RUN:  busy = 1'b1;
            FILL_DONE: done = 1'b1;
            default:   ;
        endcase
        wr_en   = busy;
        wr_addr = addr_q;
        lo_data = ENT_W'(addr_q) * ENT_W'(const_q[NIB_W-1:0]);
        hi_data = ENT_W'(addr_q) * ENT_W'(const_q[2*NIB_W-1:NIB_W]);
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy)); // R6
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && addr_q != LAST) |=> busy && addr_q == $past(addr_q) + 1'b1); // R7
    AST_HOLD_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && hold) |=> !busy); // R8

endmodule

// File: rtl/lutmul_const_mult.sv
module lutmul_const_mult
    import lutmul_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] DEFAULT_CONST = 'hAB,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [DATA_W-1:0]   in_data,
    output logic                out_valid,
    output logic [2*DATA_W-1:0] out_product,
    input  logic                load_en,
    input  logic [1:0]          load_sel,
    input  logic [DATA_W/2-1:0] load_addr,
    input  logic [DATA_W-1:0]   load_data,
    input  logic                fill_start,
    input  logic [DATA_W-1:0]   fill_const,
    output logic                fill_busy,
    output logic                fill_done
);
    localparam int NIB_W  = DATA_W / 2;
    localparam int ENT_W  = 2 * NIB_W;
    localparam int PP_W   = DATA_W + NIB_W;
    localparam int PROD_W = 2 * DATA_W;

    logic               f_we;
    logic [NIB_W-1:0]   f_addr;
    logic [ENT_W-1:0]   f_data [NUM_PARTS];
    logic [PP_W-1:0]    pp [NUM_PARTS];
    logic [PROD_W-1:0]  prod_c;
    logic               accept;

    lutmul_filler #(.NIB_W(NIB_W), .ENT_W(ENT_W)) u_fill (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (fill_start),
        .hold    (load_en),
        .const_in(fill_const),
        .busy    (fill_busy),
        .done    (fill_done),
        .wr_en   (f_we),
        .wr_addr (f_addr),
        .lo_data (f_data[0]),
        .hi_data (f_data[1])
    );

    for (genvar p = 0; p < NUM_PARTS; p++) begin : g_part
        logic [1:0]       we;
        logic [ENT_W-1:0] wdata;
        logic [NIB_W-1:0] waddr;

        for (genvar t = 0; t < TBL_PER_PART; t++) begin : g_we
            assign we[t] = f_we |
                (load_en && !fill_busy && load_sel == 2'(p * TBL_PER_PART + t));
        end
        assign wdata = f_we ? f_data[p] : load_data;
        assign waddr = f_we ? f_addr    : load_addr;

        lutmul_partial #(
            .NIB_W   (NIB_W),
            .ENT_W   (ENT_W),
            .PP_W    (PP_W),
            .INIT_NIB(DEFAULT_CONST[p*NIB_W +: NIB_W])
        ) u_part (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (we),
            .wr_addr(waddr),
            .wr_data(wdata),
            .operand(in_data),
            .pp     (pp[p])
        );
    end

    assign prod_c = PROD_W'(pp[0]) + (PROD_W'(pp[1]) << NIB_W);
    assign accept = in_valid && !load_en && !fill_busy;

    if (OUT_REG) begin : g_reg
        logic              vld_q;
        logic [PROD_W-1:0] prod_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q  <= 1'b0;
                prod_q <= '0;
            end else begin
                vld_q <= accept;
                if (accept) prod_q <= prod_c;
            end
        end
        assign out_valid   = vld_q;
        assign out_product = prod_q;

        AST_VALID_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> $past(in_valid)); // R2
        AST_QUIET_WHILE_LOADING: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (!$past(load_en) && !$past(fill_busy))); // R5
        AST_HOLD_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
            !out_valid |-> $stable(out_product)); // R3
    end else begin : g_comb
        assign out_valid   = accept;
        assign out_product = prod_c;
    end

endmodule

// File: tb/lutmul_const_mult_test.sv
module lutmul_const_mult_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        out_valid;
    logic [15:0] out_product;
    logic        load_en = 1'b0;
    logic [1:0]  load_sel = '0;
    logic [3:0]  load_addr = '0;
    logic [7:0]  load_data = '0;
    logic        fill_start = 1'b0;
    logic [7:0]  fill_const = '0;
    logic        fill_busy;
    logic        fill_done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    logic [15:0] expq [$];
    logic [15:0] last_prod = '0;

    always #4 clk = ~clk;

    lutmul_const_mult uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_product(out_product),
        .load_en(load_en), .load_sel(load_sel), .load_addr(load_addr),
        .load_data(load_data), .fill_start(fill_start), .fill_const(fill_const),
        .fill_busy(fill_busy), .fill_done(fill_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver: one input per falling edge; queue the expected product if accepted
    task automatic drive(input bit v, input logic [7:0] d, input bit accepted,
                         input logic [15:0] exp);
        @(negedge clk);
        in_valid = v;
        in_data  = d;
        if (v && accepted) expq.push_back(exp);
    endtask

    task automatic sweep(input int k);
        for (int i = 0; i < 256; i++) begin
            if (i % 7 == 3) drive(1'b0, 8'h00, 1'b0, 16'h0);
            drive(1'b1, 8'(i), 1'b1, 16'(i * k));
        end
        drive(1'b0, 8'h00, 1'b0, 16'h0);
    endtask

    // Monitor: result due on the rising edge after the sampling edge
    always @(posedge clk) begin
        #2;
        if (rst_n && !finished) begin
            if (out_valid) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R5 unexpected out_valid", 1, 0);
                end else begin
                    logic [15:0] e;
                    e = expq.pop_front();
                    check(out_product == e, "R2 product", out_product, e);
                end
                last_prod = out_product;
            end else begin
                if (expq.size() != 0) begin
                    check(1'b0, "R2 missing out_valid", 0, 1);
                    void'(expq.pop_front());
                end
                check(out_product == last_prod, "R3 hold", out_product, last_prod);
            end
        end
    end

    initial begin
        #200000;
        check(1'b0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        check(fill_busy == 1'b0, "R1 fill_busy", fill_busy, 0);
        check(fill_done == 1'b0, "R1 fill_done", fill_done, 0);
        check(out_product == 16'h0, "R1 out_product", out_product, 0);
        rst_n = 1'b1;

        // R1/R2: default constant 171 over all operands
        sweep(171);

        // R4/R5: manual load of constant 0x5E while inputs keep arriving
        for (int s = 0; s < 4; s++) begin
            for (int a = 0; a < 16; a++) begin
                @(negedge clk);
                load_en   = 1'b1;
                load_sel  = 2'(s);
                load_addr = 4'(a);
                load_data = 8'(a * ((s < 2) ? 14 : 5));
                in_valid  = 1'b1;
                in_data   = 8'(a * 13);
            end
        end
        @(negedge clk);
        load_en  = 1'b0;
        in_valid = 1'b0;
        sweep(94);

        // R4: select code 3 = high const nibble, high operand nibble; T3[15] = 0
        @(negedge clk);
        load_en = 1'b1; load_sel = 2'd3; load_addr = 4'hF; load_data = 8'h00;
        @(negedge clk);
        load_en = 1'b0;
        in_valid = 1'b1; in_data = 8'hFF;
        expq.push_back(16'd4770);   // 210 + 16*210 + 16*(75 + 0)
        drive(1'b1, 8'h0F, 1'b1, 16'd1410); // T0[F]+16*T1[0]+16*(T2[F]+16*T3[0]) = 210+16*75
        drive(1'b0, 8'h00, 1'b0, 16'h0);

        // R8: fill_start with load_en high is ignored (write rewrites same value)
        @(negedge clk);
        load_en = 1'b1; load_sel = 2'd0; load_addr = 4'h0; load_data = 8'h00;
        fill_start = 1'b1; fill_const = 8'h33;
        @(negedge clk);
        fill_start = 1'b0; load_en = 1'b0;
        check(fill_busy == 1'b0, "R8 fill_busy", fill_busy, 0);
        @(negedge clk);
        check(fill_busy == 1'b0, "R8 fill_busy later", fill_busy, 0);

        // R6/R7: fill constant 0xFF, with stray writes and restarts
        fill_start = 1'b1; fill_const = 8'hFF;
        for (int k = 1; k <= 18; k++) begin
            @(negedge clk);
            fill_start = (k == 9);
            fill_const = 8'h12;
            in_valid   = (k <= 16);
            in_data    = 8'hC3;
            load_en    = (k <= 8);
            load_sel   = 2'(k);
            load_addr  = 4'(k);
            load_data  = 8'h5A;
            if (k <= 16) begin
                check(fill_busy == 1'b1, "R6 busy window", fill_busy, 1);
                check(fill_done == 1'b0, "R6 no early done", fill_done, 0);
            end else if (k == 17) begin
                check(fill_done == 1'b1, "R6 done pulse", fill_done, 1);
                check(fill_busy == 1'b0, "R6 busy cleared", fill_busy, 0);
            end else begin
                check(fill_done == 1'b0, "R6 done single", fill_done, 0);
                check(fill_busy == 1'b0, "R7 no restart", fill_busy, 0);
            end
        end
        load_en = 1'b0;
        in_valid = 1'b0;
        sweep(255);   // R7: stray writes and restarts left no trace

        // R6: third constant via fill
        @(negedge clk);
        fill_start = 1'b1; fill_const = 8'h01;
        @(negedge clk);
        fill_start = 1'b0;
        repeat (17) @(negedge clk);
        sweep(1);

        repeat (3) @(negedge clk);
        check(expq.size() == 0, "R2 queue drained", expq.size(), 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule